// File: doc/BRIEF.md
# Filtered Temperature Supervisor with Hysteresis

This block turns periodic comparator readings into settled over-temperature decisions for two channels. The battery channel drives a charge-enable output. It uses two thresholds, so that charging does not toggle while the temperature sits between them. One comparator reports that the sensor voltage is under the lower threshold, which means hot. The other reports that it is over the upper threshold, which means cool. The device channel watches a single over-temperature comparator. A confirmed event sets a sticky status bit and emits a one-cycle interrupt.

Both channels pace their readings with a shared time-base strobe. A window spans `WINDOW_TICKS` strobes, and `NUM_SAMPLES` readings are taken in it, spaced evenly at `WINDOW_TICKS/NUM_SAMPLES` strobes apart. A decision changes only at the last reading of a window, and only when every reading of that window falls in the same class. Each channel runs only while its own condition holds: a charge mode for the battery, active mode for the device. Each channel starts a fresh window whenever its condition becomes true.

Top module: `temp_supervisor`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `chg_en` is 1 and `dev_ovt` and `dev_irq` are 0.
- R2: A battery reading is hot when `bat_lo_trip` is 1, whatever `bat_hi_trip` is. If every reading of a completed battery window is hot, `chg_en` is 0 from the cycle after the final reading.
- R3: A battery reading is cool when `bat_hi_trip` is 1 and `bat_lo_trip` is 0. If every reading of a completed battery window is cool, `chg_en` is 1 from the cycle after the final reading.
- R4: A battery window keeps `chg_en` unchanged in two cases: its readings are not all in one class, or they all lie between the thresholds (both trips 0).
- R5: While `fast_chg` and `trickle_chg` are both 0, battery readings are ignored and `chg_en` holds its value.
- R6: When a channel's enabling condition goes from false to true, that channel starts a new window. Readings taken before the drop are discarded.
- R7: If every reading of a completed device window has `dev_hot` = 1, `dev_ovt` becomes 1 in the next cycle. `dev_irq` is 1 for exactly that one cycle, but only if `dev_ovt` was 0 before.
- R8: `dev_ovt` stays 1 until `ovt_clr` is sampled high. A confirmation in the same cycle as `ovt_clr` wins, and the bit stays or becomes 1.
- R9: While `active_mode` is 0, device readings are ignored, and `dev_ovt` and `dev_irq` do not rise.
- R10: A reading is taken on every `WINDOW_TICKS/NUM_SAMPLES`-th `tick` of an enabled channel. Outputs change only in the cycle after a `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, one cycle per time unit |
| bat_lo_trip | input | 1 | Battery sensor under lower threshold (hot) |
| bat_hi_trip | input | 1 | Battery sensor over upper threshold (cool) |
| dev_hot | input | 1 | Device over-temperature comparator |
| fast_chg | input | 1 | Fast-charge mode flag |
| trickle_chg | input | 1 | Trickle-charge mode flag |
| active_mode | input | 1 | Active-mode flag, enables device channel |
| ovt_clr | input | 1 | Clears the device status bit |
| chg_en | output | 1 | Charge enable |
| dev_ovt | output | 1 | Sticky device over-temperature status |
| dev_irq | output | 1 | One-cycle interrupt on status rise |

## Verification
Two situations are hard to reach from the ports. The first is a window abandoned partway through. The bench feeds two hot battery readings, drops and restores the charge mode, and then feeds one more hot reading. A design that kept the stale history would clear `chg_en` at that point. The second is a collision between `ovt_clr` and a confirmation. The bench raises the clear strobe in the same cycle as the final tick of a hot window, once with the status bit clear and once with it already set. Battery behaviour is swept over every class combination of a three-reading window, from both starting states of `chg_en`.

// File: rtl/tsup_pkg.sv
package tsup_pkg;
  typedef enum logic [1:0] {
    CLS_MID  = 2'd0,
    CLS_HOT  = 2'd1,
    CLS_COOL = 2'd2
  } tsup_cls_e;
endpackage

// File: rtl/tsup_window.sv
// Per-channel window pacing: counts time-base strobes while enabled and
// flags each reading point and the final reading of a window.
module tsup_window #(
  parameter int SPACING = 2,
  parameter int NSMP    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  output logic take,
  output logic last
);
  localparam int CW = (SPACING > 1) ? $clog2(SPACING) : 1;
  localparam int IW = (NSMP > 1) ? $clog2(NSMP) : 1;

  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          at_pt;

  assign at_pt = (cnt == CW'(SPACING - 1));
  assign take  = en && tick && at_pt;
  assign last  = take && (idx == IW'(NSMP - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      idx <= '0;
    end else if (tick) begin
      if (at_pt) begin
        cnt <= '0;
        idx <= (idx == IW'(NSMP - 1)) ? '0 : idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsup_agree.sv
// Keeps the earlier readings of a window and reports whether the final
// reading matches all of them.
module tsup_agree
  import tsup_pkg::*;
#(
  parameter int NSMP = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      take,
  input  logic      last,
  input  tsup_cls_e cur,
  output logic      unanimous
);
  localparam int HD = (NSMP > 1) ? NSMP - 1 : 1;

  tsup_cls_e hist [HD];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      for (int i = 0; i < HD; i++) hist[i] <= CLS_MID;
    end else if (take && !last) begin
      hist[0] <= cur;
      for (int i = 1; i < HD; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    unanimous = 1'b1;
    if (NSMP > 1) begin
      for (int i = 0; i < HD; i++)
        if (hist[i] != cur) unanimous = 1'b0;
    end
  end
endmodule

// File: rtl/temp_supervisor.sv
module temp_supervisor
  import tsup_pkg::*;
#(
  parameter int WINDOW_TICKS = 128,
  parameter int NUM_SAMPLES  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic bat_lo_trip,
  input  logic bat_hi_trip,
  input  logic dev_hot,
  input  logic fast_chg,
  input  logic trickle_chg,
  input  logic active_mode,
  input  logic ovt_clr,
  output logic chg_en,
  output logic dev_ovt,
  output logic dev_irq
);
  localparam int SPACING = (WINDOW_TICKS / NUM_SAMPLES > 0) ? WINDOW_TICKS / NUM_SAMPLES : 1;
  localparam int NCH     = 2;
  localparam int CH_BAT  = 0;
  localparam int CH_DEV  = 1;

  logic [NCH-1:0] ch_en, ch_take, ch_last, ch_unan;
  tsup_cls_e      ch_cls [NCH];

  // battery: hot has priority over cool
  always_comb begin
    if (bat_lo_trip)      ch_cls[CH_BAT] = CLS_HOT;
    else if (bat_hi_trip) ch_cls[CH_BAT] = CLS_COOL;
    else                  ch_cls[CH_BAT] = CLS_MID;
    ch_cls[CH_DEV] = dev_hot ? CLS_HOT : CLS_COOL;
  end

  assign ch_en[CH_BAT] = fast_chg | trickle_chg;
  assign ch_en[CH_DEV] = active_mode;

  for (genvar g = 0; g < NCH; g++) begin : gen_ch
    tsup_window #(.SPACING(SPACING), .NSMP(NUM_SAMPLES)) u_win (
      .clk  (clk),
      .rst  (rst),
      .en   (ch_en[g]),
      .tick (tick),
      .take (ch_take[g]),
      .last (ch_last[g])
    );
    tsup_agree #(.NSMP(NUM_SAMPLES)) u_agr (
      .clk       (clk),
      .rst       (rst),
      .en        (ch_en[g]),
      .take      (ch_take[g]),
      .last      (ch_last[g]),
      .cur       (ch_cls[g]),
      .unanimous (ch_unan[g])
    );
  end

  logic bat_ok, dev_set;
  assign bat_ok  = ch_last[CH_BAT] && ch_unan[CH_BAT];
  assign dev_set = ch_last[CH_DEV] && ch_unan[CH_DEV] && (ch_cls[CH_DEV] == CLS_HOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_en  <= 1'b1;
      dev_ovt <= 1'b0;
      dev_irq <= 1'b0;
    end else begin
      if (bat_ok) begin
        if (ch_cls[CH_BAT] == CLS_HOT)       chg_en <= 1'b0;
        else if (ch_cls[CH_BAT] == CLS_COOL) chg_en <= 1'b1;
      end
      dev_irq <= dev_set && !dev_ovt;
      if (dev_set)      dev_ovt <= 1'b1;
      else if (ovt_clr) dev_ovt <= 1'b0;
    end
  end
endmodule

// File: rtl/tsup_checker.sv
module tsup_checker (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic bat_lo_trip,
  input logic bat_hi_trip,
  input logic fast_chg,
  input logic trickle_chg,
  input logic active_mode,
  input logic ovt_clr,
  input logic chg_en,
  input logic dev_ovt,
  input logic dev_irq
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst) dev_irq |=> !dev_irq); // R7
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst) dev_irq |-> (dev_ovt && !$past(dev_ovt))); // R7
  AST_OVT_STICKY: assert property (@(posedge clk) disable iff (rst) ($past(dev_ovt) && !$past(ovt_clr)) |-> dev_ovt); // R8
  AST_OVT_GATED: assert property (@(posedge clk) disable iff (rst) $rose(dev_ovt) |-> $past(active_mode)); // R9
  AST_CHG_GATED: assert property (@(posedge clk) disable iff (rst) !$past(fast_chg || trickle_chg) |-> $stable(chg_en)); // R5
  AST_CHG_FALL_HOT: assert property (@(posedge clk) disable iff (rst) $fell(chg_en) |-> $past(bat_lo_trip)); // R2
  AST_CHG_RISE_COOL: assert property (@(posedge clk) disable iff (rst) $rose(chg_en) |-> $past(bat_hi_trip && !bat_lo_trip)); // R3
  AST_CHG_ON_TICK: assert property (@(posedge clk) disable iff (rst) !$past(tick) |-> $stable(chg_en)); // R10
endmodule

bind temp_supervisor tsup_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .bat_lo_trip (bat_lo_trip),
  .bat_hi_trip (bat_hi_trip),
  .fast_chg    (fast_chg),
  .trickle_chg (trickle_chg),
  .active_mode (active_mode),
  .ovt_clr     (ovt_clr),
  .chg_en      (chg_en),
  .dev_ovt     (dev_ovt),
  .dev_irq     (dev_irq)
);

// File: tb/temp_supervisor_bench.sv
module temp_supervisor_bench;
  localparam int WT = 6;
  localparam int NS = 3;
  localparam int SP = WT / NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, bat_lo_trip = 1'b0, bat_hi_trip = 1'b0, dev_hot = 1'b0;
  logic fast_chg = 1'b0, trickle_chg = 1'b0, active_mode = 1'b0, ovt_clr = 1'b0;
  logic chg_en, dev_ovt, dev_irq;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  temp_supervisor #(.WINDOW_TICKS(WT), .NUM_SAMPLES(NS)) u_temp_supervisor (
    .clk(clk), .rst(rst), .tick(tick), .bat_lo_trip(bat_lo_trip), .bat_hi_trip(bat_hi_trip),
    .dev_hot(dev_hot), .fast_chg(fast_chg), .trickle_chg(trickle_chg), .active_mode(active_mode),
    .ovt_clr(ovt_clr), .chg_en(chg_en), .dev_ovt(dev_ovt), .dev_irq(dev_irq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // b: 0 between, 1 hot, 2 cool, 3 both trips (hot)
  task automatic reading(input int b, input bit d, input bit clr_end);
    bat_lo_trip = (b == 1 || b == 3);
    bat_hi_trip = (b == 2 || b == 3);
    dev_hot = d;
    for (int t = 0; t < SP; t++) begin
      @(negedge clk);
      tick = 1'b1;
      if (clr_end && t == SP - 1) ovt_clr = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      ovt_clr = 1'b0;
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); ovt_clr = 1'b1;
    @(negedge clk); ovt_clr = 1'b0;
  endtask

  function automatic int cls_of(input int b);
    return (b == 3) ? 1 : b;
  endfunction

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic exp_chg;
    repeat (3) @(negedge clk);
    check("R1 chg_en in reset", chg_en, 1'b1);
    check("R1 dev_ovt in reset", dev_ovt, 1'b0);
    check("R1 dev_irq in reset", dev_irq, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 chg_en after reset", chg_en, 1'b1);
    check("R1 dev_ovt after reset", dev_ovt, 1'b0);

    // R5/R9: channels idle while gating is off
    for (int k = 0; k < NS; k++) reading(1, 1'b1, 1'b0);
    check("R5 chg_en held without charge mode", chg_en, 1'b1);
    check("R9 dev_ovt held outside active mode", dev_ovt, 1'b0);
    check("R9 no irq outside active mode", dev_irq, 1'b0);

    // battery sweep over every class triple, both starting states
    exp_chg = 1'b1;
    for (int start = 0; start < 2; start++) begin
      for (int code = 0; code < 64; code++) begin
        int c [3];
        @(negedge clk);
        fast_chg = (start == 0);
        trickle_chg = (start == 1);
        for (int k = 0; k < NS; k++) reading(start == 0 ? 1 : 2, 1'b0, 1'b0);
        exp_chg = (start == 1);
        check(start == 0 ? "R2 prime hot" : "R3 prime cool", chg_en, exp_chg);
        c[0] = code % 4; c[1] = (code / 4) % 4; c[2] = code / 16;
        for (int k = 0; k < NS; k++) reading(c[k], 1'b0, 1'b0);
        if (cls_of(c[0]) == cls_of(c[1]) && cls_of(c[1]) == cls_of(c[2])) begin
          if (cls_of(c[0]) == 1) exp_chg = 1'b0;
          else if (cls_of(c[0]) == 2) exp_chg = 1'b1;
        end
        check("R4 battery window decision (R2/R3)", chg_en, exp_chg);
      end
    end

    // R5: held low while gating off
    @(negedge clk); fast_chg = 1'b1; trickle_chg = 1'b0;
    for (int k = 0; k < NS; k++) reading(1, 1'b0, 1'b0);
    @(negedge clk); fast_chg = 1'b0;
    for (int k = 0; k < NS; k++) reading(2, 1'b0, 1'b0);
    check("R5 chg_en low held without charge mode", chg_en, 1'b0);

    // R6: restart of a battery window
    @(negedge clk); trickle_chg = 1'b1;
    for (int k = 0; k < NS; k++) reading(2, 1'b0, 1'b0);
    check("R6 prime cool", chg_en, 1'b1);
    reading(1, 1'b0, 1'b0);
    reading(1, 1'b0, 1'b0);
    @(negedge clk); trickle_chg = 1'b0;
    @(negedge clk); trickle_chg = 1'b1;
    reading(1, 1'b0, 1'b0);
    check("R6 stale readings discarded", chg_en, 1'b1);
    reading(2, 1'b0, 1'b0);
    reading(2, 1'b0, 1'b0);
    check("R6 mixed window after restart holds", chg_en, 1'b1);
    for (int k = 0; k < NS; k++) reading(1, 1'b0, 1'b0);
    check("R10 aligned window after restart", chg_en, 1'b0);
    @(negedge clk); trickle_chg = 1'b0;

    // device sweep
    @(negedge clk); active_mode = 1'b1;
    for (int p = 0; p < 8; p++) begin
      pulse_clear();
      check("R8 cleared by ovt_clr", dev_ovt, 1'b0);
      for (int k = 0; k < NS; k++) reading(0, p[k], 1'b0);
      check("R7 dev_ovt after window", dev_ovt, p == 7);
      check("R7 irq with rise", dev_irq, p == 7);
      @(negedge clk);
      check("R7 irq single cycle", dev_irq, 1'b0);
    end

    // sticky against cool window
    for (int k = 0; k < NS; k++) reading(0, 1'b0, 1'b0);
    check("R8 sticky through cool window", dev_ovt, 1'b1);
    // already set, hot again with clear at the same edge
    for (int k = 0; k < NS; k++) reading(0, 1'b1, k == NS - 1);
    check("R8 set wins over clear", dev_ovt, 1'b1);
    check("R7 no irq when already set", dev_irq, 1'b0);
    pulse_clear();
    check("R8 plain clear", dev_ovt, 1'b0);
    for (int k = 0; k < NS; k++) reading(0, 1'b1, k == NS - 1);
    check("R8 set wins over clear from zero", dev_ovt, 1'b1);
    check("R7 irq on set with clear", dev_irq, 1'b1);

    // R9 restart: leaving active mode drops partial device window
    pulse_clear();
    reading(0, 1'b1, 1'b0);
    reading(0, 1'b1, 1'b0);
    @(negedge clk); active_mode = 1'b0;
    @(negedge clk); active_mode = 1'b1;
    reading(0, 1'b1, 1'b0);
    check("R6 device window restarts", dev_ovt, 1'b0);
    reading(0, 1'b1, 1'b0);
    check("R10 no decision before last reading", dev_ovt, 1'b0);
    reading(0, 1'b1, 1'b0);
    check("R10 decision at last reading", dev_ovt, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule